// File: doc/BRIEF.md
# Presettable Binary Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter with a parallel preset. On each rising clock edge it either loads a preset word, holds its value, or adds one. An active-low flag reports when the count sits at all ones. When the reload control is high, that flag is fed back internally, so the counter reloads the preset instead of wrapping to zero. This makes a programmable modulus divider without any load logic outside the block.

The preset P gives a terminal-count pulse every 2^WIDTH − P clocks. A master reset clears the count and raises the flag at once, with no clock needed. Its release passes through a short synchronizer, so the first active edge after reset falls at a known point. Both control enables are active low. The load enable takes priority over the count enable.

Top module: `preset_counter`

## Requirements
- R1: While `rst_async` is high, `count` is 0 and `tc_n` is 1. Both take effect without a clock edge, and no load, count or reload input can change them.
- R2: After `rst_async` falls, the first SYNC_STAGES rising edges leave `count` at 0. The next edge applies the selected operation, so in count mode `count` is 1 after edge SYNC_STAGES+1.
- R3: With `load_n` = 0, a rising edge copies `preset` into `count`. This happens whatever the levels of `cnt_en_n` and `reload_on_tc`.
- R4: With `load_n` = 1, `cnt_en_n` = 0 and `reload_on_tc` = 0, each rising edge adds one to `count`. All ones is followed by zero.
- R5: With `load_n` = 1 and `cnt_en_n` = 1, `count` keeps its value across edges. This holds whatever `reload_on_tc` is, including at all ones.
- R6: `tc_n` is 0 exactly when `count` is all ones and 1 otherwise. It is decoded from the registered count, so it changes on the same edge as `count`.
- R7: With `load_n` = 1, `cnt_en_n` = 0 and `reload_on_tc` = 1, an edge taken while `count` is all ones loads `preset`. At any other value the edge adds one.
- R8: In reload mode with a fixed preset P, `tc_n` goes low once every 2^WIDTH − P clocks, for every P from 0 to all ones. P = all ones holds `tc_n` low continuously, a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_async | input | 1 | Master reset, active high, asynchronous assert, synchronized release |
| load_n | input | 1 | Parallel load enable, active low, highest synchronous priority |
| cnt_en_n | input | 1 | Count enable, active low |
| reload_on_tc | input | 1 | High: reload preset at all ones instead of wrapping |
| preset | input | WIDTH | Preset word loaded by `load_n` or by terminal-count reload |
| count | output | WIDTH | Registered count value |
| tc_n | output | 1 | Terminal count, low while `count` is all ones |

## Verification
The bench builds the counter with WIDTH = 4 and SYNC_STAGES = 2. At that width every count value can be preloaded and then hit with all eight combinations of load, enable and reload control. The wrap and the reload at all ones are therefore exercised from every starting value, not just sampled. The small width also lets the bench measure the terminal-count period for every preset 0 through 15 and compare it with 16 − P. Reset is applied both at start-up and in the middle of operation, and the edges of the synchronized release are counted one by one.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Operation applied to the count register on the next rising edge
  typedef enum logic [1:0] {
    PC_HOLD   = 2'd0,
    PC_INC    = 2'd1,
    PC_LOAD   = 2'd2,
    PC_RELOAD = 2'd3
  } pc_op_e;

  // Priority: explicit load, then hold, then terminal-count reload, then increment
  function automatic pc_op_e pc_pick_op(input logic load_n, input logic en_n,
                                        input logic reload, input logic at_top);
    if (!load_n)            return PC_LOAD;
    else if (en_n)          return PC_HOLD;
    else if (reload && at_top) return PC_RELOAD;
    else                    return PC_INC;
  endfunction

endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '0;
    else      chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];

  // R1: the synchronized reset is low in every cycle the master reset is sampled high
  sync_follows_arst_chk: assert property (@(posedge clk) disable iff (1'b0)
    arst |-> !rst_n_sync);
endmodule

// File: rtl/pc_tc_decode.sv
module pc_tc_decode #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count_q,
  output logic             at_top,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  function automatic logic is_top(input logic [WIDTH-1:0] v);
    return v == TOP;
  endfunction

  assign at_top = is_top(count_q);
  assign tc_n   = ~at_top;
endmodule

// File: rtl/pc_count_reg.sv
module pc_count_reg
  import pc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pc_op_e           op,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count_q
);
  function automatic logic [WIDTH-1:0] succ(input logic [WIDTH-1:0] v);
    return v + {{(WIDTH-1){1'b0}}, 1'b1};
  endfunction

  logic ev_inc, ev_hold, ev_load;
  assign ev_inc  = (op == PC_INC);
  assign ev_hold = (op == PC_HOLD);
  assign ev_load = (op == PC_LOAD) || (op == PC_RELOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else begin
      case (op)
        PC_INC:    count_q <= succ(count_q);
        PC_LOAD,
        PC_RELOAD: count_q <= preset;
        default:   count_q <= count_q;
      endcase
    end
  end

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inc |=> count_q == succ($past(count_q)));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $stable(count_q));
  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> count_q == $past(preset));
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import pc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_async,
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic             reload_on_tc,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             tc_n
);
  logic   rst_n_int;
  logic   at_top;
  pc_op_e op;

  pc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst(rst_async), .rst_n_sync(rst_n_int)
  );

  assign op = pc_pick_op(load_n, cnt_en_n, reload_on_tc, at_top);

  pc_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_n_int), .op(op), .preset(preset), .count_q(count)
  );

  pc_tc_decode #(.WIDTH(WIDTH)) u_tc (
    .count_q(count), .at_top(at_top), .tc_n(tc_n)
  );

  // R2
  release_hold_chk: assert property (@(posedge clk) disable iff (rst_async)
    !rst_n_int |=> count == '0);
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_n && !cnt_en_n && !reload_on_tc && !tc_n) |=> (count == '0 && tc_n));
  // R7
  tc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_n && !cnt_en_n && reload_on_tc && !tc_n) |=> count == $past(preset));
endmodule

// File: tb/sim_preset_counter.sv
module sim_preset_counter;
  localparam int W    = 4;
  localparam int ST   = 2;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_async = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en_n = 1'b1;
  logic         reload_on_tc = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         tc_n;

  preset_counter #(.WIDTH(W), .SYNC_STAGES(ST)) u0 (
    .clk(clk), .rst_async(rst_async), .load_n(load_n), .cnt_en_n(cnt_en_n),
    .reload_on_tc(reload_on_tc), .preset(preset), .count(count), .tc_n(tc_n)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q = 0;
  bit done  = 0;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  // Drive one operation, update the bench model, sample 1 ns after the edge
  task automatic apply(input logic ld, input logic en, input logic rl,
                       input int p, input string req);
    load_n = ld; cnt_en_n = en; reload_on_tc = rl; preset = p[W-1:0];
    if (!ld) exp_q = p;
    else if (!en) begin
      if (rl && exp_q == MAXV) exp_q = p;
      else exp_q = (exp_q + 1) % (MAXV + 1);
    end
    edge_wait();
    check(req, int'(count), exp_q);
    check("R6 tc_n", int'(tc_n), (exp_q == MAXV) ? 0 : 1);
  endtask

  // Assert reset mid-cycle, verify, then release and count synchronizer edges
  task automatic reset_cycle();
    #2 rst_async = 1'b1;
    #1;
    check("R1 count async", int'(count), 0);
    check("R1 tc_n async", int'(tc_n), 1);
    load_n = 1'b0; preset = 4'd9; cnt_en_n = 1'b0; reload_on_tc = 1'b1;
    edge_wait();
    edge_wait();
    check("R1 count under load", int'(count), 0);
    check("R1 tc_n under load", int'(tc_n), 1);
    rst_async = 1'b0;
    load_n = 1'b1; cnt_en_n = 1'b0; reload_on_tc = 1'b0;
    for (int k = 0; k < ST; k++) begin
      edge_wait();
      check("R2 sync window", int'(count), 0);
    end
    edge_wait();
    check("R2 first count", int'(count), 1);
    exp_q = 1;
  endtask

  initial begin
    rst_async = 1'b1;
    #2;
    check("R1 count at start", int'(count), 0);
    check("R1 tc_n at start", int'(tc_n), 1);
    edge_wait();
    reset_cycle();

    // Every start value against every control combination
    for (int s = 0; s <= MAXV; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic ld, en, rl;
        string tag;
        ld = c[2]; en = c[1]; rl = c[0];
        if (!ld)     tag = "R3 load";
        else if (en) tag = "R5 hold";
        else if (rl) tag = "R7 reload";
        else         tag = "R4 count";
        apply(1'b0, 1'b0, 1'b0, s, "R3 preload");
        apply(ld, en, rl, (s * 5 + 3) % (MAXV + 1), tag);
        apply(ld, en, rl, (s * 7 + 1) % (MAXV + 1), tag);
      end
    end

    // Long continuous run, two full wraps
    apply(1'b0, 1'b1, 1'b0, 0, "R3 preload");
    for (int k = 0; k < 2 * (MAXV + 1); k++) apply(1'b1, 1'b0, 1'b0, 6, "R4 wrap run");

    // Mid-operation reset
    apply(1'b0, 1'b0, 1'b0, 10, "R3 preload");
    reset_cycle();

    // Divide-ratio period for every preset
    for (int p = 0; p <= MAXV; p++) begin
      int g;
      int m;
      apply(1'b0, 1'b0, 1'b1, p, "R3 preload");
      g = 0;
      while (tc_n !== 1'b0 && g < 40) begin
        apply(1'b1, 1'b0, 1'b1, p, "R7 reload run");
        g++;
      end
      m = 0;
      do begin
        apply(1'b1, 1'b0, 1'b1, p, "R7 reload run");
        m++;
      end while (tc_n !== 1'b0 && m < 40);
      check("R8 period", m, MAXV + 1 - p);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule